// File: doc/BRIEF.md
# Address-Masked General-Purpose I/O Block

This block is an eight-pin general-purpose I/O peripheral sitting on a simple 32-bit register bus with a 4 KB window. Software reaches the pin data through a 1 KB region in which the word address itself carries a pin mask. A read shows only the selected pins. A write touches only the selected pins that are also configured as outputs. This lets a driver flip one pin without a read-modify-write sequence.

Besides the data path, the block holds:
- a direction register;
- per-pin interrupt configuration, which chooses level or edge detection, the polarity, and whether both edges count;
- a sticky raw status, a masked status and a single interrupt line;
- an alternate-function selection whose writes are filtered by a commit mask, with the commit mask itself protected by a keyed lock;
- eight pad-control storage words;
- a read-only identification table at the top of the window.

Inputs pass through a two-flop synchronizer before they are read or examined for interrupts.

Top module: `agpio_top`

## Requirements
- R1: After reset, every register reads zero except commit, which reads 0xFF, and the lock word at 0x520, which reads 1 (locked). `pin_out`, `pin_oe` and `irq` are all zero.
- R2: A read at any offset below 0x400 returns the pin levels ANDed with address bits [9:2], and all other bits read zero. A pin's level is its stored data bit when it is an output, and its synchronized input otherwise. A change on `pin_in` is visible to a read two clock edges after it is sampled.
- R3: A write at an offset below 0x400 changes only the data bits that are set both in address bits [9:2] and in the direction register. All other data bits keep their values.
- R4: The direction register at 0x400 marks output pins with a 1. `pin_oe` equals direction, and `pin_out` equals stored data ANDed with direction.
- R5: A write to the alternate-function register at 0x420 changes only the bits that are set in the commit register, and the register reads back at the same offset.
- R6: Writing 0x0ACCE551 to 0x520 unlocks the block. Writing any other value there locks it. Reading 0x520 returns 1 in bit 0 when the block is locked.
- R7: The commit register at 0x524 accepts a write only while the block is unlocked, and it reads back at the same offset.
- R8: Offsets 0x500, 0x504, …, 0x51C each hold an 8-bit value that reads back as written.
- R9: Word offsets 0xFD0 to 0xFFC read one identification byte each, in index order: 00,00,00,00,61,00,18,01,0D,F0,05,B1.
- R10: A pin whose sense bit (0x404) is 0 is edge-triggered. Its both-edges bit (0x408) set means any edge counts. Otherwise its event bit (0x40C) selects rising (1) or falling (0). A detected edge sets the raw status bit (0x414) three clock edges after the input change is sampled. The bit stays set until a 1 is written to that bit of the clear register at 0x41C.
- R11: A pin whose sense bit is 1 is level-triggered. Its raw status bit follows whether the synchronized input equals its event bit, and writes to the clear register do not affect it.
- R12: The masked status at 0x418 equals raw status ANDed with the mask register at 0x410. `irq` is high exactly when any masked status bit is set.
- R13: Reads of offsets with no register return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is combinational, so the bench samples it one nanosecond after presenting the address, inside the same low clock phase. A write takes effect at the next rising edge, so it is checked by a read in the following cycle. An input change is visible in the data region after two edges, and in raw status and `irq` after three. The directed interrupt checks therefore sample once after two edges, where the old value is expected, and again after the third, where the new value is expected. Every random input change is followed by three idle edges before any read is compared against the model.

// File: rtl/agpio_pkg.sv
package agpio_pkg;
    parameter int PINS     = 8;
    parameter int ADDR_W   = 12;
    parameter int PAD_REGS = 8;

    localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_BOTH   = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_EVT    = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_IMASK  = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MIS    = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 12'h41C;
    localparam logic [ADDR_W-1:0] OFF_ALTFN  = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_PADS   = 12'h500;
    localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFF_COMMIT = 12'h524;
    localparam logic [ADDR_W-1:0] OFF_IDTAB  = 12'hFD0;
    localparam logic [31:0]       UNLOCK_KEY = 32'h0ACC_E551;

    typedef struct packed {
        logic [PINS-1:0]                data;
        logic [PINS-1:0]                dir;
        logic [PINS-1:0]                sense;
        logic [PINS-1:0]                both;
        logic [PINS-1:0]                evt;
        logic [PINS-1:0]                imask;
        logic [PINS-1:0]                altfn;
        logic [PINS-1:0]                commit;
        logic [PAD_REGS-1:0][PINS-1:0]  pad;
        logic                           locked;
    } regs_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd4:    return 8'h61;
            4'd6:    return 8'h18;
            4'd7:    return 8'h01;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/agpio_sync.sv
module agpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/agpio_irq_detect.sv
module agpio_irq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] raw
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] raw;
    } det_t;

    det_t         det_d, det_q;
    logic [W-1:0] rise, fall, edge_hit, lvl_hit;

    always_comb begin
        rise     = lvl & ~det_q.prev;
        fall     = ~lvl & det_q.prev;
        edge_hit = (both & (rise | fall))
                 | (~both & evt & rise)
                 | (~both & ~evt & fall);
        lvl_hit  = ~(lvl ^ evt);
        det_d      = det_q;
        det_d.prev = lvl;
        det_d.raw  = (sense & lvl_hit)
                   | (~sense & (edge_hit | (det_q.raw & ~clr)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign raw = det_q.raw;
endmodule

// File: rtl/agpio_top.sv
module agpio_top
    import agpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    regs_t            st_d, st_q;
    logic [PINS-1:0]  sync_in, raw, clr, sel_mask, wmask, pin_val, wd8;
    logic             wr_go, is_data, pad_hit, id_hit;
    logic [2:0]       pad_idx;
    logic [ADDR_W-1:0] id_off;

    agpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in)
    );

    agpio_irq_detect #(.W(PINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl(sync_in),
        .sense(st_q.sense), .both(st_q.both), .evt(st_q.evt),
        .clr(clr), .raw(raw)
    );

    assign wr_go    = bus_sel & bus_wr;
    assign is_data  = (bus_addr[ADDR_W-1:10] == '0);
    assign sel_mask = bus_addr[2 +: PINS];
    assign wmask    = sel_mask & st_q.dir;
    assign wd8      = bus_wdata[PINS-1:0];
    assign pad_hit  = (bus_addr[ADDR_W-1:5] == OFF_PADS[ADDR_W-1:5]) && (bus_addr[1:0] == 2'b00);
    assign pad_idx  = bus_addr[4:2];
    assign id_hit   = (bus_addr >= OFF_IDTAB) && (bus_addr[1:0] == 2'b00);
    assign id_off   = bus_addr - OFF_IDTAB;
    assign pin_val  = (st_q.dir & st_q.data) | (~st_q.dir & sync_in);

    // next-state of the register file
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr_go) begin
            if (is_data) begin
                st_d.data = (st_q.data & ~wmask) | (wd8 & wmask);
            end else if (pad_hit) begin
                st_d.pad[pad_idx] = wd8;
            end else begin
                case (bus_addr)
                    OFF_DIR:    st_d.dir   = wd8;
                    OFF_SENSE:  st_d.sense = wd8;
                    OFF_BOTH:   st_d.both  = wd8;
                    OFF_EVT:    st_d.evt   = wd8;
                    OFF_IMASK:  st_d.imask = wd8;
                    OFF_CLR:    clr        = wd8;
                    OFF_ALTFN:  st_d.altfn = (st_q.altfn & ~st_q.commit) | (wd8 & st_q.commit);
                    OFF_LOCK:   st_d.locked = (bus_wdata != UNLOCK_KEY);
                    OFF_COMMIT: if (!st_q.locked) st_d.commit = wd8;
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.commit <= '1;
            st_q.locked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // read decode
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (is_data) begin
                bus_rdata[PINS-1:0] = pin_val & sel_mask;
            end else if (pad_hit) begin
                bus_rdata[PINS-1:0] = st_q.pad[pad_idx];
            end else if (id_hit) begin
                bus_rdata[7:0] = id_byte(id_off[5:2]);
            end else begin
                case (bus_addr)
                    OFF_DIR:    bus_rdata[PINS-1:0] = st_q.dir;
                    OFF_SENSE:  bus_rdata[PINS-1:0] = st_q.sense;
                    OFF_BOTH:   bus_rdata[PINS-1:0] = st_q.both;
                    OFF_EVT:    bus_rdata[PINS-1:0] = st_q.evt;
                    OFF_IMASK:  bus_rdata[PINS-1:0] = st_q.imask;
                    OFF_RAW:    bus_rdata[PINS-1:0] = raw;
                    OFF_MIS:    bus_rdata[PINS-1:0] = raw & st_q.imask;
                    OFF_ALTFN:  bus_rdata[PINS-1:0] = st_q.altfn;
                    OFF_LOCK:   bus_rdata[0]        = st_q.locked;
                    OFF_COMMIT: bus_rdata[PINS-1:0] = st_q.commit;
                    default:    ;
                endcase
            end
        end
    end

    assign pin_out = st_q.data & st_q.dir;
    assign pin_oe  = st_q.dir;
    assign irq     = |(raw & st_q.imask);

    // plain views of state for the bound checker
    logic [PINS-1:0] data_q, dir_q, altfn_q, commit_q, imask_q;
    logic            locked_q;
    assign data_q   = st_q.data;
    assign dir_q    = st_q.dir;
    assign altfn_q  = st_q.altfn;
    assign commit_q = st_q.commit;
    assign imask_q  = st_q.imask;
    assign locked_q = st_q.locked;
endmodule

// File: rtl/agpio_top_chk.sv
module agpio_top_chk
    import agpio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [PINS-1:0]   data_q,
    input logic [PINS-1:0]   dir_q,
    input logic [PINS-1:0]   altfn_q,
    input logic [PINS-1:0]   commit_q,
    input logic [PINS-1:0]   imask_q,
    input logic [PINS-1:0]   raw,
    input logic              locked_q,
    input logic              irq
);
    logic data_wr, lock_wr, commit_wr, altfn_wr;
    assign data_wr   = bus_sel && bus_wr && (bus_addr[ADDR_W-1:10] == '0);
    assign lock_wr   = bus_sel && bus_wr && (bus_addr == OFF_LOCK);
    assign commit_wr = bus_sel && bus_wr && (bus_addr == OFF_COMMIT);
    assign altfn_wr  = bus_sel && bus_wr && (bus_addr == OFF_ALTFN);

    // R3
    data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (((data_q ^ $past(data_q)) & ~($past(dir_q) & $past(bus_addr[9:2]))) == '0));

    // R5
    altfn_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        altfn_wr |=> (((altfn_q ^ $past(altfn_q)) & ~$past(commit_q)) == '0));

    // R6
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && bus_wdata == UNLOCK_KEY) |=> !locked_q);

    // R6
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && bus_wdata != UNLOCK_KEY) |=> locked_q);

    // R7
    commit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr && locked_q) |=> $stable(commit_q));

    // R12
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != '0 && imask_q != '0));
endmodule

bind agpio_top agpio_top_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .data_q(data_q),
    .dir_q(dir_q), .altfn_q(altfn_q), .commit_q(commit_q),
    .imask_q(imask_q), .raw(raw), .locked_q(locked_q), .irq(irq)
);

// File: tb/agpio_top_tb.sv
module agpio_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0, pin_out, pin_oe;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_data = '0, m_dir = '0, m_altfn = '0, m_commit = 8'hFF;
    logic       m_locked = 1'b1;

    agpio_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_id(input int i);
        logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                               8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[i];
    endfunction

    function automatic logic [7:0] exp_data_rd(input logic [7:0] mask);
        return ((m_dir & m_data) | (~m_dir & pin_in)) & mask;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(12'h400, v); check("R1 dir", v, 0);
        rd(12'h524, v); check("R1 commit", v, 32'hFF);
        rd(12'h520, v); check("R1 lock", v, 1);
        rd(12'h420, v); check("R1 altfn", v, 0);
        rd(12'h414, v); check("R1 raw", v, 0);
        check("R1 pin_out", {pin_oe, pin_out, 7'd0, irq}, 0);

        // R2 input latency
        @(negedge clk); pin_in = 8'h81;
        @(negedge clk); peek(12'h3FC, v); check("R2 before sync", v, 0);
        @(negedge clk); peek(12'h3FC, v); check("R2 after sync", v, 32'h81);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [7:0] msk, d8;
            op  = int'($urandom % 7);
            msk = 8'($urandom);
            d8  = 8'($urandom);
            case (op)
                0: begin
                    wr({2'b00, msk, 2'b00}, {24'($urandom), d8});
                    m_data = (m_data & ~(msk & m_dir)) | (d8 & msk & m_dir);
                    @(negedge clk); #1;
                    check("R3 pin_out after data write", pin_out, m_data & m_dir);
                end
                1: begin
                    rd({2'b00, msk, 2'b00}, v);
                    check("R2 masked data read", v, {24'd0, exp_data_rd(msk)});
                end
                2: begin
                    wr(12'h400, {24'd0, d8}); m_dir = d8;
                    @(negedge clk); #1;
                    check("R4 pin_oe", pin_oe, m_dir);
                    check("R4 pin_out", pin_out, m_data & m_dir);
                end
                3: begin
                    wr(12'h420, {24'd0, d8});
                    m_altfn = (m_altfn & ~m_commit) | (d8 & m_commit);
                    rd(12'h420, v); check("R5 altfn", v, {24'd0, m_altfn});
                end
                4: begin
                    if ($urandom % 2) begin wr(12'h520, 32'h0ACCE551); m_locked = 0; end
                    else begin wr(12'h520, $urandom); m_locked = 1; end
                    rd(12'h520, v); check("R6 lock", v, {31'd0, m_locked});
                end
                5: begin
                    wr(12'h524, {24'd0, d8});
                    if (!m_locked) m_commit = d8;
                    rd(12'h524, v); check("R7 commit", v, {24'd0, m_commit});
                end
                default: begin
                    @(negedge clk); pin_in = d8;
                    idle(3);
                end
            endcase
        end

        // directed: lock key off by one is rejected
        wr(12'h520, 32'h0ACCE551); wr(12'h520, 32'h0ACCE550); m_locked = 1;
        wr(12'h524, 32'h3C);
        rd(12'h524, v); check("R7 commit kept while locked", v, {24'd0, m_commit});

        // R8 pad storage
        for (int i = 0; i < 8; i++) wr(12'h500 + 12'(i * 4), 32'(8'hA0 + i));
        for (int i = 0; i < 8; i++) begin
            rd(12'h500 + 12'(i * 4), v); check("R8 pad", v, 32'(8'hA0 + i));
        end

        // R9 identification bytes
        for (int i = 0; i < 12; i++) begin
            rd(12'hFD0 + 12'(i * 4), v); check("R9 id", v, {24'd0, exp_id(i)});
        end

        // R13 undefined offsets
        wr(12'h428, 32'hFFFF_FFFF); wr(12'h600, 32'hFFFF_FFFF);
        rd(12'h428, v); check("R13 undef read", v, 0);
        rd(12'h600, v); check("R13 undef read2", v, 0);
        rd(12'h400, v); check("R13 dir untouched", v, {24'd0, m_dir});
        rd(12'h420, v); check("R13 altfn untouched", v, {24'd0, m_altfn});

        // interrupts
        wr(12'h400, 0); m_dir = 0;
        @(negedge clk); pin_in = 8'h00;
        idle(4);
        wr(12'h404, 32'h04);
        wr(12'h408, 32'h08);
        wr(12'h40C, 32'h15);
        wr(12'h410, 32'h0F);
        wr(12'h41C, 32'hFF);
        idle(2);
        rd(12'h414, v); check("R10 raw cleared", v, 0);
        check("R12 irq idle", irq, 0);

        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk); peek(12'h414, v); check("R10 raw not yet", v, 0);
        @(negedge clk); peek(12'h414, v); check("R10 rising", v, 32'h01);
        #1 check("R12 irq rising", irq, 1);
        rd(12'h418, v); check("R12 masked", v, 32'h01);
        wr(12'h41C, 32'h01);
        rd(12'h414, v); check("R10 clear", v, 0);
        check("R12 irq cleared", irq, 0);

        @(negedge clk); pin_in[1] = 1'b1; idle(4);
        rd(12'h414, v); check("R10 falling ignores rise", v, 0);
        @(negedge clk); pin_in[1] = 1'b0; idle(4);
        rd(12'h414, v); check("R10 falling", v, 32'h02);
        wr(12'h41C, 32'h02);

        @(negedge clk); pin_in[3] = 1'b1; idle(4);
        rd(12'h414, v); check("R10 both rise", v, 32'h08);
        wr(12'h41C, 32'h08);
        @(negedge clk); pin_in[3] = 1'b0; idle(4);
        rd(12'h414, v); check("R10 both fall", v, 32'h08);
        wr(12'h41C, 32'h08);

        @(negedge clk); pin_in[4] = 1'b1; idle(4);
        rd(12'h414, v); check("R12 raw unmasked pin", v, 32'h10);
        rd(12'h418, v); check("R12 masked off", v, 0);
        check("R12 irq masked off", irq, 0);
        wr(12'h41C, 32'h10);

        @(negedge clk); pin_in[2] = 1'b1; idle(4);
        rd(12'h414, v); check("R11 level high", v, 32'h04);
        check("R12 irq level", irq, 1);
        wr(12'h41C, 32'h04);
        rd(12'h414, v); check("R11 clear ignored", v, 32'h04);
        @(negedge clk); pin_in[2] = 1'b0; idle(4);
        rd(12'h414, v); check("R11 level low", v, 0);
        check("R12 irq gone", irq, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule